// File: doc/BRIEF.md
# Programmable Down-Counting Timer with Waveform Output

This block is a general purpose timer built around a down counter whose width is set by a parameter (32 bits by default). An arm pulse loads the counter from a preload value. The counter then drops by one on every counting clock. Reaching zero is the terminal count, and there the timer either stops or reloads the preload and carries on. A configuration input chooses what starts and gates the counting:
- software only (the arm pulse),
- a rising edge on an external trigger, or
- the trigger held high.

A single output pin follows one of six waveform styles, chosen by a mode input:
- latched low,
- a one-clock low pulse,
- a multi-clock low pulse,
- toggle,
- pulse width modulation against a compare value,
- a one-shot window.

Every terminal count sets a sticky interrupt flag. The flag stays set until a clear input is pulsed. The interrupt output is that flag gated by an enable bit. A system that needs two timers instantiates the block twice. All configuration arrives on plain input ports.

Top module: `gp_timer`

## Requirements
- R1: Straight after reset the timer is idle, `tmr_out_o` is high and `irq_o` is low.
- R2: A one-clock pulse on `arm_i` loads the preload. Each counting clock then decrements the count by one, and terminal count happens on the counting clock that finds the count at zero. With software start (`trig_mode_i` = 0), the interrupt flag is therefore set on the P+1-th rising edge after the edge that sampled `arm_i` (P = preload).
- R3: When `reload_i` = 0, the timer goes idle at terminal count and raises no further terminal counts until it is armed again.
- R4: When `reload_i` = 1, the counter is reloaded from the preload at terminal count, so terminal counts repeat every P+1 clocks.
- R5: In edge-trigger mode (`trig_mode_i` = 1), an armed timer waits and does not count until it samples a 0-to-1 transition on `trig_i`. A trigger that is already high when the timer is armed does not start it.
- R6: In level-trigger mode (`trig_mode_i` = 2), the armed timer counts only on clocks where `trig_i` is high, and it keeps its count while `trig_i` is low.
- R7: Each terminal count sets a pending flag that stays set until `irq_clr_i` is sampled high; a terminal count in the same cycle wins over the clear. `irq_o` equals the pending flag AND `irq_en_i`. The enable bit does not alter the pending flag.
- R8: Latch-low mode (`out_mode_i` = 0): the pin goes low at terminal count and stays low until the next arm pulse, which drives it high again.
- R9: Short-pulse mode (`out_mode_i` = 1) drives the pin low for exactly 1 clock at terminal count. Long-pulse mode (`out_mode_i` = 2) drives it low for exactly LONG_LEN clocks (default 4).
- R10: Toggle mode (`out_mode_i` = 3): the pin inverts at every terminal count and is set high by an arm pulse.
- R11: PWM mode (`out_mode_i` = 4): `tmr_out_o` is high exactly when the current count is greater than `compare_i`. Reload is forced on whatever the value of `reload_i`.
- R12: One-shot mode (`out_mode_i` = 5): the pin goes low on the arm pulse and returns high at terminal count. The timer then halts even if `reload_i` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| arm_i | input | 1 | One-clock pulse: load preload and start or await trigger |
| preload_i | input | WIDTH | Value loaded into the counter |
| compare_i | input | WIDTH | PWM threshold |
| reload_i | input | 1 | 1 = reload at terminal count, 0 = halt |
| out_mode_i | input | 3 | Output waveform code, 0 to 5 |
| trig_mode_i | input | 2 | 0 software, 1 rising edge, 2 level high |
| trig_i | input | 1 | External trigger, synchronous to clk_i |
| irq_en_i | input | 1 | Interrupt enable |
| irq_clr_i | input | 1 | Clears the pending flag |
| tmr_out_o | output | 1 | Timer output pin |
| irq_o | output | 1 | Enabled interrupt |

## Verification
The bench builds the timer with WIDTH = 16 and the default LONG_LEN of 4. Preloads of a few counts then put every terminal count, reload wrap and pulse end within a handful of clocks, so each can be checked on its exact edge. The narrower counter still passes through the zero-compare, the reload and the greater-than PWM compare that a 32-bit build uses. Keeping LONG_LEN at 4 means the long pulse is measured at its real length, with a check on the last low clock and another on the first high one.

// File: rtl/gp_timer_pkg.sv
package gp_timer_pkg;

    typedef enum logic [2:0] {
        OM_LATCH   = 3'd0,
        OM_SHORT   = 3'd1,
        OM_LONG    = 3'd2,
        OM_TOGGLE  = 3'd3,
        OM_PWM     = 3'd4,
        OM_ONESHOT = 3'd5
    } out_mode_e;

    typedef enum logic [1:0] {
        TM_SOFT  = 2'd0,
        TM_EDGE  = 2'd1,
        TM_LEVEL = 2'd2
    } trig_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } run_state_e;

    // PWM always wraps; one-shot always stops; the rest obey the control bit.
    function automatic logic reload_effective(out_mode_e m, logic rl);
        if (m == OM_PWM)
            return 1'b1;
        else if (m == OM_ONESHOT)
            return 1'b0;
        else
            return rl;
    endfunction

endpackage

// File: rtl/gp_timer_counter.sv
module gp_timer_counter
    import gp_timer_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             arm_i,
    input  logic [WIDTH-1:0] preload_i,
    input  trig_mode_e       trig_mode_i,
    input  logic             trig_i,
    input  logic             reload_i,
    output logic [WIDTH-1:0] cnt_o,
    output logic             tc_o
);

    run_state_e       state_q;
    logic [WIDTH-1:0] cnt_q;
    logic             trig_prev_q;
    logic             count_en;
    logic             trig_rise;

    assign trig_rise = trig_i && !trig_prev_q;
    assign count_en  = (state_q == ST_RUN) && ((trig_mode_i != TM_LEVEL) || trig_i);
    assign tc_o      = count_en && (cnt_q == '0) && !arm_i;
    assign cnt_o     = cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q     <= ST_IDLE;
            cnt_q       <= '0;
            trig_prev_q <= 1'b0;
        end else begin
            trig_prev_q <= trig_i;
            if (arm_i) begin
                cnt_q   <= preload_i;
                state_q <= (trig_mode_i == TM_EDGE) ? ST_WAIT : ST_RUN;
            end else begin
                case (state_q)
                    ST_WAIT: if (trig_rise) state_q <= ST_RUN;
                    ST_RUN: begin
                        if (tc_o) begin
                            if (reload_i) cnt_q <= preload_i;
                            else          state_q <= ST_IDLE;
                        end else if (count_en) begin
                            cnt_q <= cnt_q - WIDTH'(1);
                        end
                    end
                    default: state_q <= state_q;
                endcase
            end
        end
    end

    // R2: a counting clock above zero lowers the count by exactly one
    p_decrement_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_RUN && count_en && cnt_q != '0 && !arm_i)
            |=> (cnt_q == $past(cnt_q) - WIDTH'(1)));

    // R3: terminal count without reload leaves the timer idle
    p_halt_idle_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (tc_o && !reload_i) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/gp_timer_wave.sv
module gp_timer_wave
    import gp_timer_pkg::*;
#(
    parameter int WIDTH    = 32,
    parameter int LONG_LEN = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             arm_i,
    input  logic             tc_i,
    input  out_mode_e        mode_i,
    input  logic [WIDTH-1:0] cnt_i,
    input  logic [WIDTH-1:0] compare_i,
    output logic             pin_o
);

    localparam int PW = $clog2(LONG_LEN + 1);

    logic          pin_q;
    logic [PW-1:0] left_q;
    logic          pulsing;

    assign pulsing = (mode_i == OM_SHORT) || (mode_i == OM_LONG);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pin_q  <= 1'b1;
            left_q <= '0;
        end else if (arm_i) begin
            pin_q  <= (mode_i != OM_ONESHOT);
            left_q <= '0;
        end else if (tc_i) begin
            case (mode_i)
                OM_LATCH:   pin_q <= 1'b0;
                OM_SHORT: begin
                    pin_q  <= 1'b0;
                    left_q <= '0;
                end
                OM_LONG: begin
                    pin_q  <= 1'b0;
                    left_q <= PW'(LONG_LEN - 1);
                end
                OM_TOGGLE:  pin_q <= !pin_q;
                OM_ONESHOT: pin_q <= 1'b1;
                default:    pin_q <= pin_q;
            endcase
        end else if (pulsing && !pin_q) begin
            if (left_q != '0) left_q <= left_q - PW'(1);
            else              pin_q  <= 1'b1;
        end
    end

    assign pin_o = (mode_i == OM_PWM) ? (cnt_i > compare_i) : pin_q;

    // R8: in latch-low mode a low pin holds until an arm pulse
    p_latch_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == OM_LATCH && !pin_q && !arm_i) |=> !pin_q);

endmodule

// File: rtl/gp_timer_irq.sv
module gp_timer_irq (
    input  logic clk_i,
    input  logic rst_i,
    input  logic tc_i,
    input  logic clr_i,
    input  logic en_i,
    output logic irq_o
);

    logic pend_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)      pend_q <= 1'b0;
        else if (tc_i)  pend_q <= 1'b1;
        else if (clr_i) pend_q <= 1'b0;
    end

    assign irq_o = pend_q && en_i;

    // R7: terminal count sets the flag
    p_irq_set_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        tc_i |=> pend_q);

    // R7: the flag persists until cleared
    p_irq_hold_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (pend_q && !clr_i) |=> pend_q);

endmodule

// File: rtl/gp_timer.sv
module gp_timer
    import gp_timer_pkg::*;
#(
    parameter int WIDTH    = 32,
    parameter int LONG_LEN = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             arm_i,
    input  logic [WIDTH-1:0] preload_i,
    input  logic [WIDTH-1:0] compare_i,
    input  logic             reload_i,
    input  logic [2:0]       out_mode_i,
    input  logic [1:0]       trig_mode_i,
    input  logic             trig_i,
    input  logic             irq_en_i,
    input  logic             irq_clr_i,
    output logic             tmr_out_o,
    output logic             irq_o
);

    out_mode_e        mode;
    trig_mode_e       tmode;
    logic             reload_eff;
    logic [WIDTH-1:0] cnt;
    logic             tc;

    assign mode       = out_mode_e'(out_mode_i);
    assign tmode      = trig_mode_e'(trig_mode_i);
    assign reload_eff = reload_effective(mode, reload_i);

    gp_timer_counter #(.WIDTH(WIDTH)) u_counter (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .arm_i       (arm_i),
        .preload_i   (preload_i),
        .trig_mode_i (tmode),
        .trig_i      (trig_i),
        .reload_i    (reload_eff),
        .cnt_o       (cnt),
        .tc_o        (tc)
    );

    gp_timer_wave #(.WIDTH(WIDTH), .LONG_LEN(LONG_LEN)) u_wave (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .arm_i     (arm_i),
        .tc_i      (tc),
        .mode_i    (mode),
        .cnt_i     (cnt),
        .compare_i (compare_i),
        .pin_o     (tmr_out_o)
    );

    gp_timer_irq u_irq (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .tc_i  (tc),
        .clr_i (irq_clr_i),
        .en_i  (irq_en_i),
        .irq_o (irq_o)
    );

endmodule

// File: tb/test_gp_timer.sv
module test_gp_timer;

    localparam int CLK_PERIOD = 10;
    localparam int WIDTH      = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             arm = 1'b0;
    logic [WIDTH-1:0] preload = '0;
    logic [WIDTH-1:0] compare = '0;
    logic             reload = 1'b0;
    logic [2:0]       out_mode = 3'd0;
    logic [1:0]       trig_mode = 2'd0;
    logic             trig = 1'b0;
    logic             irq_en = 1'b1;
    logic             irq_clr = 1'b0;
    logic             tmr_out;
    logic             irq;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = !clk;

    gp_timer #(.WIDTH(WIDTH), .LONG_LEN(4)) i_gp_timer (
        .clk_i       (clk),
        .rst_i       (rst),
        .arm_i       (arm),
        .preload_i   (preload),
        .compare_i   (compare),
        .reload_i    (reload),
        .out_mode_i  (out_mode),
        .trig_mode_i (trig_mode),
        .trig_i      (trig),
        .irq_en_i    (irq_en),
        .irq_clr_i   (irq_clr),
        .tmr_out_o   (tmr_out),
        .irq_o       (irq)
    );

    task automatic chk(input string what, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // arm pulse with a flag clear; returns just after the sampling edge
    task automatic do_arm(input int p, input logic [2:0] m, input logic [1:0] tm, input logic rl);
        @(negedge clk);
        preload = WIDTH'(p); out_mode = m; trig_mode = tm; reload = rl;
        arm = 1'b1; irq_clr = 1'b1;
        @(negedge clk);
        arm = 1'b0; irq_clr = 1'b0;
    endtask

    task automatic clear_irq();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 out after reset", tmr_out, 1'b1);
        chk("R1 irq after reset", irq, 1'b0);
    endtask

    task automatic t_halt_latch();
        do_arm(5, 3'd0, 2'd0, 1'b0);
        wait_n(5);
        chk("R2 no irq before P+1 edges", irq, 1'b0);
        chk("R8 pin high before tc", tmr_out, 1'b1);
        wait_n(1);
        chk("R2 irq on edge P+1", irq, 1'b1);
        chk("R8 pin low at tc", tmr_out, 1'b0);
        clear_irq();
        wait_n(20);
        chk("R3 no tc after halt", irq, 1'b0);
        chk("R8 pin stays low", tmr_out, 1'b0);
        do_arm(50, 3'd0, 2'd0, 1'b0);
        chk("R8 rearm drives pin high", tmr_out, 1'b1);
    endtask

    task automatic t_reload_toggle();
        do_arm(3, 3'd3, 2'd0, 1'b1);
        chk("R10 pin high after arm", tmr_out, 1'b1);
        wait_n(4);
        chk("R10 first toggle", tmr_out, 1'b0);
        chk("R4 first tc", irq, 1'b1);
        clear_irq();
        chk("R7 clear drops irq", irq, 1'b0);
        wait_n(2);
        chk("R4 no tc mid period", irq, 1'b0);
        wait_n(1);
        chk("R4 second tc after P+1", irq, 1'b1);
        chk("R10 second toggle", tmr_out, 1'b1);
    endtask

    task automatic t_mask();
        irq_en = 1'b0;
        do_arm(2, 3'd0, 2'd0, 1'b0);
        wait_n(3);
        chk("R7 masked irq low", irq, 1'b0);
        irq_en = 1'b1;
        #1;
        chk("R7 pending kept under mask", irq, 1'b1);
        wait_n(5);
        chk("R7 pending holds", irq, 1'b1);
        clear_irq();
        chk("R7 cleared", irq, 1'b0);
    endtask

    task automatic t_pulses();
        do_arm(2, 3'd1, 2'd0, 1'b0);
        wait_n(3);
        chk("R9 short pulse low", tmr_out, 1'b0);
        wait_n(1);
        chk("R9 short pulse ends after 1", tmr_out, 1'b1);
        do_arm(2, 3'd2, 2'd0, 1'b0);
        wait_n(3);
        chk("R9 long pulse low", tmr_out, 1'b0);
        wait_n(3);
        chk("R9 long pulse 4th clock low", tmr_out, 1'b0);
        wait_n(1);
        chk("R9 long pulse ends after 4", tmr_out, 1'b1);
    endtask

    task automatic t_edge();
        @(negedge clk) trig = 1'b1;
        do_arm(2, 3'd0, 2'd1, 1'b0);
        wait_n(10);
        chk("R5 held-high trigger no start", irq, 1'b0);
        trig = 1'b0;
        wait_n(1);
        trig = 1'b1;
        wait_n(3);
        chk("R5 not yet tc after edge", irq, 1'b0);
        wait_n(1);
        chk("R5 tc P+1 after edge", irq, 1'b1);
        trig = 1'b0;
    endtask

    task automatic t_level();
        do_arm(3, 3'd0, 2'd2, 1'b0);
        wait_n(10);
        chk("R6 no count while low", irq, 1'b0);
        trig = 1'b1;
        wait_n(2);
        trig = 1'b0;
        wait_n(10);
        chk("R6 count frozen while low", irq, 1'b0);
        trig = 1'b1;
        wait_n(1);
        chk("R6 one count left", irq, 1'b0);
        wait_n(1);
        chk("R6 tc after remaining counts", irq, 1'b1);
        trig = 1'b0;
    endtask

    task automatic t_pwm();
        compare = WIDTH'(3);
        do_arm(7, 3'd4, 2'd0, 1'b0);
        chk("R11 high at count 7", tmr_out, 1'b1);
        wait_n(3);
        chk("R11 high at count 4", tmr_out, 1'b1);
        wait_n(1);
        chk("R11 low at count equal compare", tmr_out, 1'b0);
        wait_n(3);
        chk("R11 low at count 0", tmr_out, 1'b0);
        wait_n(1);
        chk("R11 forced reload high", tmr_out, 1'b1);
    endtask

    task automatic t_oneshot();
        do_arm(4, 3'd5, 2'd0, 1'b1);
        chk("R12 low on start", tmr_out, 1'b0);
        wait_n(4);
        chk("R12 low until tc", tmr_out, 1'b0);
        wait_n(1);
        chk("R12 high at tc", tmr_out, 1'b1);
        chk("R12 tc irq", irq, 1'b1);
        clear_irq();
        wait_n(12);
        chk("R12 halted despite reload", irq, 1'b0);
        chk("R12 pin stays high", tmr_out, 1'b1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        wait_n(3);
        rst = 1'b0;
        wait_n(1);
        t_reset();
        t_halt_latch();
        t_reload_toggle();
        t_mask();
        t_pulses();
        t_edge();
        t_level();
        t_pwm();
        t_oneshot();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule